// File: doc/BRIEF.md
# Clock and Data Activity Alarm Monitor

This block watches a serial clock and its serial data line from a free-running reference clock and raises two alarms: one when the serial clock stops toggling, and one when the data line stops changing while the clock still runs. Both alarms are sticky. Once raised, an alarm stays high after activity comes back, so software sees every loss event even if the loss was short.

A single alarm-reset input is used as a pulse protocol, not as a level reset. Each high-then-low pulse on it counts as one toggle, detected on the falling edge after synchronization. The first toggle opens a polling window, shown on `pollWindow`. A second toggle inside that window clears both alarms and closes the window. If no second toggle arrives within the window length, the window closes and the toggle count goes back to zero. The monitored clock, the data line and the alarm-reset input are all asynchronous to the reference clock, and each passes through its own synchronizer.

Top module: `lam_top`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it rises, `lossClkAlarm`, `lossDataAlarm` and `pollWindow` are 0.
- R2: `lossClkAlarm` goes to 1 once the synchronized `serClkIn` shows no edge for CLK_TIMEOUT (64) reference cycles. Edge gaps well below that limit, for example 40 cycles, never raise it.
- R3: `lossDataAlarm` goes to 1 once DATA_TIMEOUT (256) rising edges of `serClkIn` pass without a transition on `serDataIn`. Data that changes at least every 200 bits never raises it.
- R4: Bit times are counted only on rising edges of `serClkIn`. A stopped clock with data held constant raises `lossClkAlarm` but not `lossDataAlarm`, as long as fewer than 256 bit times were counted first.
- R5: Both alarms are sticky. Each stays at 1 after clock or data activity resumes, until the clear sequence of R7 occurs.
- R6: One high-then-low pulse on `alarmRstIn` sets `pollWindow` to 1 and leaves both alarms unchanged.
- R7: A second falling edge of `alarmRstIn` while `pollWindow` is 1 clears both alarms whose loss condition has ended, and returns `pollWindow` to 0.
- R8: `pollWindow` returns to 0 by itself after TOGGLE_WINDOW (1024) reference cycles with no second toggle. A toggle after that point counts as a first toggle again and clears nothing.
- R9: If a clear happens while a loss condition still holds, the set wins. The affected alarm stays at 1.
- R10: Toggles are taken from the falling edge only. Raising and holding `alarmRstIn` high leaves `pollWindow` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClkIn | input | 1 | Monitored serial clock, asynchronous |
| serDataIn | input | 1 | Monitored serial data, asynchronous |
| alarmRstIn | input | 1 | Alarm-reset pulse input, asynchronous |
| lossClkAlarm | output | 1 | Sticky loss-of-clock alarm |
| lossDataAlarm | output | 1 | Sticky loss-of-data alarm |
| pollWindow | output | 1 | High while the first toggle waits for a second one |

## Verification
The clear strobe from the toggle sequencer and the set condition from an idle counter can land in the same reference cycle. The bench provokes this by holding the data line constant with the clock running, so the data idle counter stays saturated, and then sending a complete two-toggle clear. Sampling well after the second toggle must show `lossDataAlarm` still high and `pollWindow` low. A second clear, sent once data activity has resumed, must then bring the alarm down. Timing-sensitive cases such as the edge-gap limit and the window timeout use stimulus that sits clearly on one side of the limit, so the synchronizer delay cannot affect the expected result.

// File: rtl/lam_pkg.sv
package lam_pkg;

  // Strobes from the toggle sequencer to the alarm datapath
  typedef struct packed {
    logic clearAlarms;  // single-cycle request to drop sticky alarms
    logic windowOpen;   // first toggle seen, waiting for second
  } ctrlStrobe_t;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_ARMED = 1'b1
  } seqState_t;

  // Number of bits needed to hold the values 0..limit
  function automatic int unsigned holdBits(int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/lam_sync.sv
module lam_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= asyncIn;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], asyncIn};
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/lam_ctrl.sv
module lam_ctrl
  import lam_pkg::*;
#(
  parameter int unsigned TOGGLE_WINDOW = 1024
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        toggleStb,
  output ctrlStrobe_t strb
);

  localparam int unsigned WW = holdBits(TOGGLE_WINDOW - 1);
  localparam logic [WW-1:0] WIN_LAST = WW'(TOGGLE_WINDOW - 1);

  seqState_t state, stateNext;
  logic [WW-1:0] winCnt, winCntNext;

  always_comb begin
    stateNext  = state;
    winCntNext = winCnt;
    strb       = '0;
    unique case (state)
      ST_IDLE: begin
        if (toggleStb) begin
          stateNext  = ST_ARMED;
          winCntNext = '0;
        end
      end
      ST_ARMED: begin
        strb.windowOpen = 1'b1;
        if (toggleStb) begin
          // second toggle wins over a timeout in the same cycle
          strb.clearAlarms = 1'b1;
          stateNext        = ST_IDLE;
        end else if (winCnt == WIN_LAST) begin
          stateNext = ST_IDLE;
        end else begin
          winCntNext = winCnt + 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      winCnt <= '0;
    end else begin
      state  <= stateNext;
      winCnt <= winCntNext;
    end
  end

endmodule

// File: rtl/lam_datapath.sv
module lam_datapath
  import lam_pkg::*;
#(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned CLK_TIMEOUT  = 64,
  parameter int unsigned DATA_TIMEOUT = 256
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        serClkIn,
  input  logic        serDataIn,
  input  logic        alarmRstIn,
  input  ctrlStrobe_t strb,
  output logic        toggleStb,
  output logic        lossClkAlarm,
  output logic        lossDataAlarm
);

  localparam int unsigned NUM_IN = 3;
  localparam int unsigned CW = holdBits(CLK_TIMEOUT);
  localparam int unsigned DW = holdBits(DATA_TIMEOUT);
  localparam logic [CW-1:0] CLK_LIMIT  = CW'(CLK_TIMEOUT);
  localparam logic [DW-1:0] DATA_LIMIT = DW'(DATA_TIMEOUT);

  // index 0: serial clock, 1: serial data, 2: alarm-reset pulse
  logic [NUM_IN-1:0] asyncVec, syncVec, prevVec;
  assign asyncVec = {alarmRstIn, serDataIn, serClkIn};

  genvar g;
  generate
    for (g = 0; g < NUM_IN; g++) begin : g_sync
      lam_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rstN    (rstN),
        .asyncIn (asyncVec[g]),
        .syncOut (syncVec[g])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevVec <= '0;
    else       prevVec <= syncVec;
  end

  logic clkEdge, bitTick, dataEdge;
  assign clkEdge   = syncVec[0] ^ prevVec[0];
  assign bitTick   = syncVec[0] & ~prevVec[0];
  assign dataEdge  = syncVec[1] ^ prevVec[1];
  assign toggleStb = ~syncVec[2] & prevVec[2];

  // Reference cycles since the last clock edge, saturating at the limit
  logic [CW-1:0] clkIdle;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   clkIdle <= '0;
    else if (clkEdge)            clkIdle <= '0;
    else if (clkIdle != CLK_LIMIT) clkIdle <= clkIdle + 1'b1;
  end

  // Bit times since the last data transition, saturating at the limit
  logic [DW-1:0] dataIdle;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              dataIdle <= '0;
    else if (dataEdge)                      dataIdle <= '0;
    else if (bitTick && dataIdle != DATA_LIMIT) dataIdle <= dataIdle + 1'b1;
  end

  logic clkLost, dataLost;
  assign clkLost  = (clkIdle == CLK_LIMIT);
  assign dataLost = (dataIdle == DATA_LIMIT);

  // Sticky alarms: a live loss condition overrides a clear request
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lossClkAlarm  <= 1'b0;
      lossDataAlarm <= 1'b0;
    end else begin
      lossClkAlarm  <= clkLost  | (lossClkAlarm  & ~strb.clearAlarms);
      lossDataAlarm <= dataLost | (lossDataAlarm & ~strb.clearAlarms);
    end
  end

endmodule

// File: rtl/lam_top.sv
module lam_top
  import lam_pkg::*;
#(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned CLK_TIMEOUT   = 64,
  parameter int unsigned DATA_TIMEOUT  = 256,
  parameter int unsigned TOGGLE_WINDOW = 1024
) (
  input  logic clk,
  input  logic rstN,
  input  logic serClkIn,
  input  logic serDataIn,
  input  logic alarmRstIn,
  output logic lossClkAlarm,
  output logic lossDataAlarm,
  output logic pollWindow
);

  ctrlStrobe_t strb;
  logic        toggleStb;

  lam_ctrl #(.TOGGLE_WINDOW(TOGGLE_WINDOW)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .toggleStb (toggleStb),
    .strb      (strb)
  );

  lam_datapath #(
    .SYNC_STAGES  (SYNC_STAGES),
    .CLK_TIMEOUT  (CLK_TIMEOUT),
    .DATA_TIMEOUT (DATA_TIMEOUT)
  ) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .serClkIn      (serClkIn),
    .serDataIn     (serDataIn),
    .alarmRstIn    (alarmRstIn),
    .strb          (strb),
    .toggleStb     (toggleStb),
    .lossClkAlarm  (lossClkAlarm),
    .lossDataAlarm (lossDataAlarm)
  );

  assign pollWindow = strb.windowOpen;

endmodule

// File: rtl/lam_checker.sv
module lam_checker
  import lam_pkg::*;
#(
  parameter int unsigned TOGGLE_WINDOW = 1024
) (
  input logic        clk,
  input logic        rstN,
  input logic        lossClkAlarm,
  input logic        lossDataAlarm,
  input logic        pollWindow,
  input ctrlStrobe_t strb,
  input logic        toggleStb
);

  // Length of the current run of pollWindow high
  logic [31:0] winLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           winLen <= '0;
    else if (pollWindow) winLen <= winLen + 1;
    else                 winLen <= '0;
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> (!lossClkAlarm && !lossDataAlarm && !pollWindow));

  p_clk_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lossClkAlarm) |-> $past(strb.clearAlarms));

  p_data_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lossDataAlarm) |-> $past(strb.clearAlarms));

  p_open_on_toggle_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pollWindow) |-> $past(toggleStb));

  p_clear_closes_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearAlarms |=> !pollWindow);

  p_window_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    winLen <= TOGGLE_WINDOW);

endmodule

bind lam_top lam_checker #(.TOGGLE_WINDOW(TOGGLE_WINDOW)) chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .lossClkAlarm  (lossClkAlarm),
  .lossDataAlarm (lossDataAlarm),
  .pollWindow    (pollWindow),
  .strb          (strb),
  .toggleStb     (toggleStb)
);

// File: tb/lam_top_tb_top.sv
module lam_top_tb_top;

  localparam time CLK_PERIOD   = 10ns;
  localparam int  CLK_TIMEOUT  = 64;
  localparam int  DATA_TIMEOUT = 256;
  localparam int  WINDOW       = 1024;
  localparam int  WATCHDOG     = 190000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0;
  logic serData = 1'b0;
  logic almRst = 1'b0;
  logic lossClk, lossData, pollWin;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  // serial stimulus controls
  bit serRun = 0;
  int serHalf = 3;
  bit dataRun = 0;
  int dataMaxGap = 50;

  always #(CLK_PERIOD/2) clk = ~clk;

  lam_top dut_i (
    .clk           (clk),
    .rstN          (rstN),
    .serClkIn      (serClk),
    .serDataIn     (serData),
    .alarmRstIn    (almRst),
    .lossClkAlarm  (lossClk),
    .lossDataAlarm (lossData),
    .pollWindow    (pollWin)
  );

  // serial clock generator, half period in reference cycles
  initial begin
    int phase = 0;
    forever begin
      @(negedge clk);
      if (serRun) begin
        if (phase >= serHalf - 1) begin
          serClk = ~serClk;
          phase = 0;
        end else phase++;
      end
    end
  end

  // serial data: random gaps in bit times between transitions
  initial begin
    int bitsLeft = 1;
    forever begin
      @(negedge serClk);
      if (dataRun) begin
        if (bitsLeft <= 0) begin
          serData = ~serData;
          bitsLeft = $urandom_range(dataMaxGap, 1);
        end else bitsLeft--;
      end
    end
  end

  // expected-value models derived from the requirements
  function automatic bit expClkLoss(int edgeGap);
    return edgeGap >= CLK_TIMEOUT;
  endfunction

  function automatic bit expDataLoss(int bitGap);
    return bitGap >= DATA_TIMEOUT;
  endfunction

  task automatic check(string req, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic waitCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseAlarmRst(int hiCycles, int loCycles);
    @(negedge clk);
    almRst = 1'b1;
    waitCycles(hiCycles);
    almRst = 1'b0;
    waitCycles(loCycles);
  endtask

  task automatic clearSequence();
    pulseAlarmRst($urandom_range(6, 2), $urandom_range(600, 10));
    pulseAlarmRst($urandom_range(6, 2), 12);
  endtask

  task automatic finishRun();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    waitCycles(WATCHDOG);
    if (!done) begin
      misses++;
      $display("FAIL watchdog actual=running expected=finished");
      finishRun();
    end
  end

  initial begin
    int s;
    s = $urandom(32'd4711);
    waitCycles(5);
    check("R1 loss-of-clock in reset", lossClk, 1'b0);
    check("R1 loss-of-data in reset", lossData, 1'b0);
    check("R1 poll window in reset", pollWin, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 loss-of-clock after reset", lossClk, 1'b0);
    check("R1 poll window after reset", pollWin, 1'b0);

    // constrained random activity: no alarm may rise (R2, R3)
    serRun = 1;
    dataRun = 1;
    for (int i = 0; i < 20; i++) begin
      serHalf = $urandom_range(6, 2);
      dataMaxGap = $urandom_range(150, 1);
      waitCycles($urandom_range(900, 300));
      check("R2 active clock", lossClk, expClkLoss(2 * 6));
      check("R3 active data", lossData, expDataLoss(151));
    end

    // slow clock, gap 40 cycles stays below the limit (R2)
    serHalf = 40;
    dataMaxGap = 10;
    waitCycles(1200);
    check("R2 edge gap 40", lossClk, expClkLoss(40));

    // stop data, run a few bits, stop clock: clock alarm only (R2, R4)
    serHalf = 3;
    waitCycles(100);
    dataRun = 0;
    waitCycles(60);
    serRun = 0;
    waitCycles(3000);
    check("R2 clock stopped", lossClk, expClkLoss(3000));
    check("R4 no bit times without clock", lossData, 1'b0);

    // resume everything: sticky (R5)
    serRun = 1;
    dataRun = 1;
    dataMaxGap = 50;
    waitCycles(400);
    check("R5 clock alarm sticky", lossClk, 1'b1);
    check("R5 data alarm quiet", lossData, 1'b0);

    // rising edge alone is not a toggle (R10)
    @(negedge clk);
    almRst = 1'b1;
    waitCycles(60);
    check("R10 held high no window", pollWin, 1'b0);
    almRst = 1'b0;
    waitCycles(10);
    check("R6 window open after first toggle", pollWin, 1'b1);
    check("R6 alarm unchanged by first toggle", lossClk, 1'b1);

    // second toggle within window clears (R7)
    waitCycles($urandom_range(500, 20));
    pulseAlarmRst(3, 12);
    check("R7 clock alarm cleared", lossClk, 1'b0);
    check("R7 window closed", pollWin, 1'b0);

    // data stuck with clock running (R3)
    dataRun = 0;
    waitCycles(DATA_TIMEOUT * 6 + 400);
    check("R3 data stuck", lossData, expDataLoss(DATA_TIMEOUT + 50));
    check("R3 clock alarm stays low", lossClk, 1'b0);

    // clear while loss persists: set wins (R9)
    clearSequence();
    check("R9 data alarm survives clear", lossData, 1'b1);
    check("R9 window closed", pollWin, 1'b0);

    // data resumes: still sticky, then a clear drops it (R5, R7)
    dataRun = 1;
    waitCycles(500);
    check("R5 data alarm sticky", lossData, 1'b1);
    clearSequence();
    check("R7 data alarm cleared", lossData, 1'b0);

    // window timeout (R8)
    serRun = 0;
    waitCycles(300);
    serRun = 1;
    waitCycles(200);
    check("R5 clock alarm set again", lossClk, 1'b1);
    pulseAlarmRst(3, 12);
    check("R6 window open", pollWin, 1'b1);
    waitCycles(WINDOW + 100);
    check("R8 window timed out", pollWin, 1'b0);
    pulseAlarmRst(3, 12);
    check("R8 late toggle reopens window", pollWin, 1'b1);
    check("R8 late toggle clears nothing", lossClk, 1'b1);
    pulseAlarmRst(3, 12);
    check("R7 clear after reopen", lossClk, 1'b0);
    check("R7 window closed after reopen", pollWin, 1'b0);

    // random clear timing after fresh clock losses (R2, R7)
    for (int i = 0; i < 4; i++) begin
      serRun = 0;
      waitCycles($urandom_range(400, 120));
      serRun = 1;
      serHalf = $urandom_range(5, 2);
      waitCycles(100);
      check("R2 random stop", lossClk, 1'b1);
      clearSequence();
      check("R7 random clear", lossClk, 1'b0);
    end

    finishRun();
  end

endmodule